// File: doc/BRIEF.md
# Chainable TDM Audio Output Serializer

This block is the serial output stage of an audio device that can share one data line with several identical devices. It takes a stereo sample pair and a word-length select, places the two samples in two consecutive 32-bit slots at the head of each time-division-multiplexed frame, and then forwards the serial stream that arrives on its chain input. The chain input is delayed by exactly two slots, so each device downstream pushes the streams of the devices before it two slots later in the frame. The device at the head of the chain has its chain input tied low, so the slots that follow the real channels read as zeros.

The block runs entirely on one fast system clock. In slave mode it oversamples an external bit clock and frame sync. In master mode it divides the system clock to make the bit clock and produces a frame sync at 50% duty over a fixed 256-bit frame. A frame starts on the falling bit-clock edge that follows a rising frame sync, as seen on the rising bit-clock edge. Data leaves most significant bit first. Each bit changes on a falling edge and is meant to be sampled on the next rising edge.

Top module: `tdm_chain_serializer`

## Requirements
- R1: The first bit of each frame is driven on the first falling bit-clock edge after a rising bit-clock edge that sees the frame sync go from low to high. Each slot is sent most significant bit first, and every bit is held from one falling edge to the next.
- R2: Frame bits 0 to 31 carry the left sample and bits 32 to 63 carry the right sample. Sample bit 31 maps to the first bit of its slot.
- R3: Word-length select: 0 selects 16 bits, 1 selects 20, 2 selects 24 and 3 selects 32. Only the top selected bits of each 32-bit sample are sent. The remaining bits of the slot are sent as zeros.
- R4: The sample pair and the word-length select are captured when the frame starts. Changes to them later in the frame do not alter that frame's output.
- R5: From frame bit 64 onward, the output equals the chain-input bit that was sampled on a rising bit-clock edge exactly 64 bit clocks earlier.
- R6: With the chain input held low, every bit from position 64 onward is zero.
- R7: In slave mode the frame length is whatever the external frame sync gives. Any multiple of 64 bit clocks (64, 128, 256, ...) is served with no change to the block.
- R8: In master mode the bit clock is the system clock divided by CLK_DIV (default 8) at 50% duty. The frame sync changes only on falling bit-clock edges. It is high for 128 and low for 128 of each 256-bit frame, and the serial data follows R1–R5.
- R9: During reset the serial data, the bit-clock output and the frame-sync output are all low.
- R10: In slave mode the bit-clock and frame-sync outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the master-mode bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | 1: generate bit clock and frame sync; 0: follow external ones |
| wlen_i | input | 2 | Word-length select (0:16, 1:20, 2:24, 3:32 bits) |
| left_i | input | 32 | Left sample, left-justified (bit 31 is the MSB) |
| right_i | input | 32 | Right sample, left-justified |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fsync_in | input | 1 | External frame sync (slave mode) |
| chain_in | input | 1 | Serial data from the upstream device, changing on falling edges |
| sdata_o | output | 1 | Serial TDM data out |
| bclk_o | output | 1 | Generated bit clock (master mode, else low) |
| fsync_o | output | 1 | Generated frame sync (master mode, else low) |

## Verification
The assertions assume that master_en changes only while reset is held. They also assume that in slave mode each half period of the external bit clock lasts several system clocks longer than the input synchronizer, so that no two bit-clock edges land inside one synchronizer window. The bench keeps to both: it resets the block around each mode change and drives a slave bit clock with six system clocks per half period. It changes frame sync and chain data only together with a falling bit-clock edge, the way an upstream device or external master would. Stimulus mixes fixed-seed random samples, word lengths, frame lengths and chain data with directed all-ones and zero-chain frames.

// File: rtl/tdm_ser_pkg.sv
// Package: shared constants and word-length helpers for the TDM serializer.
// Assumes a fixed 32-bit slot with samples presented left-justified.
package tdm_ser_pkg;

    localparam int SLOT_W = 32;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_e;

    // Number of valid sample bits for a word-length select code.
    function automatic logic [5:0] wlen_bits(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd16;
            2'd1:    return 6'd20;
            2'd2:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    // Keep-mask with ones on the top wlen_bits positions of a slot.
    function automatic logic [SLOT_W-1:0] wlen_mask(input logic [1:0] sel);
        logic [SLOT_W-1:0] m;
        for (int i = 0; i < SLOT_W; i++) begin
            m[i] = ((SLOT_W - i) <= int'(wlen_bits(sel)));
        end
        return m;
    endfunction

endpackage

// File: rtl/tdm_bit_timing.sv
// Module: tdm_bit_timing
// Produces single-cycle falling/rising bit-clock ticks in the system clock
// domain, plus the frame-sync level and the synchronized chain bit.
// Slave: external bclk/fsync/chain pass through SYNC_STAGES flops and bclk
// edges are detected. Master: clk is divided by CLK_DIV into a bit clock and
// a 50% frame sync of FRAME_BCLKS bits changing on falling edges.
// Assumes: CLK_DIV even and >= 2; master_en only changes under reset.
module tdm_bit_timing #(
    parameter int CLK_DIV     = 8,
    parameter int FRAME_BCLKS = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic chain_in,
    output logic fall_tick,
    output logic rise_tick,
    output logic fs_level,
    output logic chain_bit,
    output logic bclk_o,
    output logic fsync_o
);

    localparam int HALF       = CLK_DIV / 2;
    localparam int DIV_W      = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int HALF_FRAME = FRAME_BCLKS / 2;
    localparam int MB_W       = $clog2(FRAME_BCLKS);

    logic [2:0]       sync_q [SYNC_STAGES];
    logic             bclk_s, fs_s;
    logic             bclk_prev_q;
    logic             slv_fall, slv_rise;
    logic [DIV_W-1:0] div_q;
    logic             div_term;
    logic             bclk_q, fsync_q;
    logic [MB_W-1:0]  mbit_q, mbit_nxt;
    logic             mst_fall, mst_rise;

    // Synchronizer chain for bclk, fsync and chain data (bit order 2..0).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= {bclk_in, fsync_in, chain_in};
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign bclk_s    = sync_q[SYNC_STAGES-1][2];
    assign fs_s      = sync_q[SYNC_STAGES-1][1];
    assign chain_bit = sync_q[SYNC_STAGES-1][0];

    // Previous synchronized bit clock, for slave edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_s;
    end

    assign slv_fall = bclk_prev_q & ~bclk_s;
    assign slv_rise = ~bclk_prev_q & bclk_s;

    assign div_term = (div_q == DIV_W'(HALF - 1));
    assign mst_fall = div_term & bclk_q;
    assign mst_rise = div_term & ~bclk_q;
    assign mbit_nxt = (mbit_q == MB_W'(FRAME_BCLKS - 1)) ? '0 : mbit_q + 1'b1;

    // Master divider, bit clock and frame counter; idle when in slave mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !master_en) begin
            div_q   <= '0;
            bclk_q  <= 1'b0;
            fsync_q <= 1'b0;
            mbit_q  <= MB_W'(FRAME_BCLKS - 1);
        end else begin
            div_q <= div_term ? '0 : div_q + 1'b1;
            if (div_term) bclk_q <= ~bclk_q;
            if (mst_fall) begin
                mbit_q  <= mbit_nxt;
                fsync_q <= (int'(mbit_nxt) < HALF_FRAME);
            end
        end
    end

    assign fall_tick = master_en ? mst_fall : slv_fall;
    assign rise_tick = master_en ? mst_rise : slv_rise;
    assign fs_level  = master_en ? fsync_q  : fs_s;
    assign bclk_o    = bclk_q;
    assign fsync_o   = fsync_q;

    // A tick is either a falling or a rising edge, never both (R1).
    p_tick_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fall_tick, rise_tick}));

    // Generated frame sync moves only with a falling bit clock (R8).
    p_fsync_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n || !master_en)
        !$stable(fsync_q) |-> $fell(bclk_q));

endmodule

// File: rtl/tdm_chain_delay.sv
// Module: tdm_chain_delay
// Delays the upstream serial stream by DEPTH bit clocks. One bit is taken
// per rising-edge tick; the oldest bit is presented on dout.
// Assumes shift_en is a single-cycle tick.
module tdm_chain_delay #(
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic din,
    output logic dout
);

    logic [DEPTH-1:0] line_q;

    // Shift one chain bit in on each rising bit-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n)        line_q <= '0;
        else if (shift_en) line_q <= {line_q[DEPTH-2:0], din};
    end

    assign dout = line_q[DEPTH-1];

    // The newest entry is the chain bit present at the tick (R5).
    p_delay_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (line_q[0] == $past(din)));

endmodule

// File: rtl/tdm_slot_shifter.sv
// Module: tdm_slot_shifter
// Detects frame start, captures the masked sample slots and shifts them out
// MSB first on falling ticks, then forwards the delayed chain bit.
// Assumes samples_i holds slot 0 in its top SLOT_W bits.
module tdm_slot_shifter
    import tdm_ser_pkg::*;
#(
    parameter int CHANS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fall_tick,
    input  logic                      rise_tick,
    input  logic                      fs_level,
    input  logic [CHANS*SLOT_W-1:0]   samples_i,
    input  logic [1:0]                wlen_i,
    input  logic                      chain_q,
    output logic                      sdata_o
);

    localparam int OWN_BITS = CHANS * SLOT_W;
    localparam int CNT_W    = $clog2(OWN_BITS + 1);
    localparam int POS_W    = $clog2(SLOT_W);

    logic [OWN_BITS-1:0] load_w;
    logic [OWN_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [1:0]          wl_q;
    logic                fs_at_rise_q, fs_at_fall_q;
    logic                frame_start;
    logic                own_phase;

    // Apply the word-length mask to each slot.
    for (genvar g = 0; g < CHANS; g++) begin : g_slot
        assign load_w[OWN_BITS-1-g*SLOT_W -: SLOT_W] =
            samples_i[OWN_BITS-1-g*SLOT_W -: SLOT_W] & wlen_mask(wlen_i);
    end

    // Frame sync as seen on the rising bit-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         fs_at_rise_q <= 1'b0;
        else if (rise_tick) fs_at_rise_q <= fs_level;
    end

    // The rising-edge view, one falling edge later, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)         fs_at_fall_q <= 1'b0;
        else if (fall_tick) fs_at_fall_q <= fs_at_rise_q;
    end

    assign frame_start = fall_tick & fs_at_rise_q & ~fs_at_fall_q;
    assign own_phase   = (cnt_q < CNT_W'(OWN_BITS));

    // Load, shift and chain-forward the serial output on falling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= CNT_W'(OWN_BITS);
            wl_q    <= WL_32;
            sdata_o <= 1'b0;
        end else if (fall_tick) begin
            if (frame_start) begin
                sdata_o <= load_w[OWN_BITS-1];
                shreg_q <= {load_w[OWN_BITS-2:0], 1'b0};
                cnt_q   <= CNT_W'(1);
                wl_q    <= wlen_i;
            end else if (own_phase) begin
                sdata_o <= shreg_q[OWN_BITS-1];
                shreg_q <= {shreg_q[OWN_BITS-2:0], 1'b0};
                cnt_q   <= cnt_q + 1'b1;
            end else begin
                sdata_o <= chain_q;
            end
        end
    end

    // Output moves only on a falling bit-clock tick (R1).
    p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_tick |=> $stable(sdata_o));

    // Slot positions below the captured word length go out as zero (R3).
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_tick && !frame_start && own_phase &&
         (int'(cnt_q[POS_W-1:0]) >= int'(wlen_bits(wl_q)))) |=> !sdata_o);

endmodule

// File: rtl/tdm_chain_serializer.sv
// Module: tdm_chain_serializer (top)
// Chainable TDM serializer: the local stereo pair in the first two 32-bit
// slots, then upstream data delayed by two slots. Master or slave framing.
// Assumes master_en is changed only while rst_n is low.
module tdm_chain_serializer
    import tdm_ser_pkg::*;
#(
    parameter int CLK_DIV     = 8,
    parameter int FRAME_BCLKS = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        master_en,
    input  logic [1:0]  wlen_i,
    input  logic [31:0] left_i,
    input  logic [31:0] right_i,
    input  logic        bclk_in,
    input  logic        fsync_in,
    input  logic        chain_in,
    output logic        sdata_o,
    output logic        bclk_o,
    output logic        fsync_o
);

    localparam int CHANS    = 2;
    localparam int OWN_BITS = CHANS * SLOT_W;

    logic fall_tick, rise_tick, fs_level, chain_bit, chain_late;

    tdm_bit_timing #(
        .CLK_DIV     (CLK_DIV),
        .FRAME_BCLKS (FRAME_BCLKS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .master_en (master_en),
        .bclk_in   (bclk_in),
        .fsync_in  (fsync_in),
        .chain_in  (chain_in),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .fs_level  (fs_level),
        .chain_bit (chain_bit),
        .bclk_o    (bclk_o),
        .fsync_o   (fsync_o)
    );

    tdm_chain_delay #(
        .DEPTH (OWN_BITS)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (rise_tick),
        .din      (chain_bit),
        .dout     (chain_late)
    );

    tdm_slot_shifter #(
        .CHANS (CHANS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .fs_level  (fs_level),
        .samples_i ({left_i, right_i}),
        .wlen_i    (wlen_i),
        .chain_q   (chain_late),
        .sdata_o   (sdata_o)
    );

    // Generated clock outputs stay quiet in slave mode (R10).
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> (!bclk_o && !fsync_o));

endmodule

// File: tb/tdm_chain_serializer_tb_top.sv
module tdm_chain_serializer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 6;
    localparam int DIV        = 8;
    localparam int NFR        = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic [1:0]  wlen_i = 2'd0;
    logic [31:0] left_i = '0;
    logic [31:0] right_i = '0;
    logic        bclk_in = 1'b0;
    logic        fsync_in = 1'b0;
    logic        chain_in = 1'b0;
    logic        sdata_o, bclk_o, fsync_o;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_chain_serializer #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .wlen_i(wlen_i),
        .left_i(left_i), .right_i(right_i), .bclk_in(bclk_in),
        .fsync_in(fsync_in), .chain_in(chain_in), .sdata_o(sdata_o),
        .bclk_o(bclk_o), .fsync_o(fsync_o)
    );

    function automatic int wl_bits(input logic [1:0] wl);
        return (wl == 2'd3) ? 32 : 16 + 4 * int'(wl);
    endfunction

    function automatic logic [31:0] pad_mask(input logic [1:0] wl);
        return 32'hFFFF_FFFF << (32 - wl_bits(wl));
    endfunction

    task automatic check(input logic got, input logic exp, input string tag);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        nvec++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // One slave bit period: fall with new fsync/chain, sample at the rise.
    task automatic bit_step(input logic fs, input logic ch, output logic got);
        bclk_in  = 1'b0;
        fsync_in = fs;
        chain_in = ch;
        repeat (HB) @(negedge clk);
        got     = sdata_o;
        bclk_in = 1'b1;
        repeat (HB) @(negedge clk);
    endtask

    task automatic slave_frame(input int F, input logic [31:0] L, input logic [31:0] R,
                               input logic [1:0] wl, input logic [31:0] nL,
                               input logic [31:0] nR, input logic [1:0] nwl,
                               input bit zero_chain, input int fr);
        logic        up [0:255];
        logic [31:0] mL, mR;
        logic        got, exp, fs;
        int          bits;
        string       tag;
        mL   = L & pad_mask(wl);
        mR   = R & pad_mask(wl);
        bits = wl_bits(wl);
        for (int i = 0; i < 256; i++) up[i] = zero_chain ? 1'b0 : (($urandom % 2) == 1);
        for (int i = 0; i < F; i++) begin
            fs = (i == F - 1) || (i < F / 2 - 1);
            if (i == 5) begin
                left_i = $urandom; right_i = $urandom; wlen_i = 2'($urandom % 4);
            end
            if (i == F - 1) begin
                left_i = nL; right_i = nR; wlen_i = nwl;
            end
            bit_step(fs, up[i], got);
            if (i < 64) begin
                exp = (i < 32) ? mL[31 - i] : mR[63 - i];
                if (i == 0)                tag = "R1";
                else if ((i % 32) >= bits) tag = "R3";
                else if (i < 32)           tag = "R2";
                else                       tag = "R4";
            end else begin
                exp = up[i - 64];
                tag = zero_chain ? "R6" : ((i >= 128) ? "R7" : "R5");
            end
            check(got, exp, $sformatf("%s slave frame %0d bit %0d", tag, fr, i));
            if (i == F / 2) begin
                check(bclk_o, 1'b0, "R10 bclk_o in slave mode");
                check(fsync_o, 1'b0, "R10 fsync_o in slave mode");
            end
        end
    endtask

    task automatic master_run();
        logic [31:0] qL [4];
        logic [31:0] qR [4];
        logic [1:0]  qW [4];
        logic        up [0:255];
        logic        pb, pfs, armed, seen, exp;
        logic [31:0] mL, mR;
        int          pos, fr, clks, since_fs, highs;
        for (int k = 0; k < 4; k++) begin
            qL[k] = $urandom; qR[k] = $urandom; qW[k] = 2'(k);
        end
        for (int i = 0; i < 256; i++) up[i] = 1'b0;
        left_i = qL[0]; right_i = qR[0]; wlen_i = qW[0];
        pb = 1'b0; pfs = 1'b0; armed = 1'b0; seen = 1'b0;
        pos = -1; fr = -1; clks = 0; since_fs = -1; highs = 0;
        mL = '0; mR = '0;
        for (int guard = 0; guard < 20000; guard++) begin
            if (fr == 2 && pos == 256) break;
            @(negedge clk);
            clks++;
            if (bclk_o && !pb) begin
                if (seen) check_int(clks, DIV, "R8 bit clock period");
                seen = 1'b1;
                clks = 0;
                if (pos >= 0 && pos < 256) begin
                    exp = (pos < 32) ? mL[31 - pos] : (pos < 64) ? mR[63 - pos] : up[pos - 64];
                    check(sdata_o, exp, $sformatf("R8 master frame %0d bit %0d", fr, pos));
                    pos++;
                end
                if (fsync_o && !pfs) begin
                    if (since_fs >= 0) begin
                        check_int(since_fs, 256, "R8 frame length");
                        check_int(highs, 128, "R8 frame sync high time");
                    end
                    since_fs = 0;
                    highs    = 0;
                    armed    = 1'b1;
                end
                if (since_fs >= 0) since_fs++;
                if (fsync_o) highs++;
                pfs = fsync_o;
            end else if (!bclk_o && pb) begin
                if (armed) begin
                    armed = 1'b0;
                    pos   = 0;
                    fr++;
                    mL = qL[fr] & pad_mask(qW[fr]);
                    mR = qR[fr] & pad_mask(qW[fr]);
                    for (int i = 0; i < 256; i++) up[i] = (($urandom % 2) == 1);
                end
                if (pos >= 0 && pos < 256) begin
                    chain_in = up[pos];
                    if (pos == 10) begin
                        left_i = $urandom; right_i = $urandom; wlen_i = 2'($urandom % 4);
                    end
                    if (pos == 250) begin
                        left_i = qL[fr + 1]; right_i = qR[fr + 1]; wlen_i = qW[fr + 1];
                    end
                end
            end
            pb = bclk_o;
        end
        check_int(fr, 2, "R8 master frames completed");
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin : stim
        int          fF [NFR];
        logic [31:0] fL [NFR];
        logic [31:0] fR [NFR];
        logic [1:0]  fW [NFR];
        bit          fZ [NFR];
        logic        got;
        void'($urandom(32'd5150));

        // Reset state, with master mode requested (R9).
        rst_n = 1'b0; master_en = 1'b1;
        repeat (6) @(negedge clk);
        check(sdata_o, 1'b0, "R9 sdata_o in reset");
        check(bclk_o, 1'b0, "R9 bclk_o in reset");
        check(fsync_o, 1'b0, "R9 fsync_o in reset");

        // Frame plan: directed corners first, then random.
        fF[0] = 128; fL[0] = 32'hFFFF_FFFF; fR[0] = 32'hFFFF_FFFF; fW[0] = 2'd0; fZ[0] = 1'b0;
        fF[1] = 128; fL[1] = $urandom;      fR[1] = $urandom;      fW[1] = 2'd1; fZ[1] = 1'b0;
        fF[2] = 256; fL[2] = $urandom;      fR[2] = $urandom;      fW[2] = 2'd2; fZ[2] = 1'b0;
        fF[3] = 64;  fL[3] = 32'h8000_0001; fR[3] = 32'h0000_0001; fW[3] = 2'd3; fZ[3] = 1'b0;
        fF[4] = 256; fL[4] = 32'h0;         fR[4] = 32'h0;         fW[4] = 2'd3; fZ[4] = 1'b1;
        for (int k = 5; k < NFR; k++) begin
            fF[k] = 64 << ($urandom % 3);
            fL[k] = $urandom; fR[k] = $urandom;
            fW[k] = 2'($urandom % 4);
            fZ[k] = 1'b0;
        end

        master_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        left_i = fL[0]; right_i = fR[0]; wlen_i = fW[0];

        // Lead-in: idle bits, then the frame sync rises.
        bit_step(1'b0, 1'b0, got);
        check(got, 1'b0, "R9 idle output after reset");
        bit_step(1'b0, 1'b0, got);
        bit_step(1'b1, 1'b0, got);
        check(got, 1'b0, "R1 no data before frame start");

        for (int k = 0; k < NFR; k++) begin
            slave_frame(fF[k], fL[k], fR[k], fW[k],
                        (k + 1 < NFR) ? fL[k + 1] : 32'h0,
                        (k + 1 < NFR) ? fR[k + 1] : 32'h0,
                        (k + 1 < NFR) ? fW[k + 1] : 2'd0,
                        fZ[k], k);
        end

        // Master mode: reset around the mode change.
        bclk_in = 1'b0; fsync_in = 1'b0; chain_in = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        repeat (3) @(negedge clk);
        check(bclk_o, 1'b0, "R9 bclk_o in reset before master run");
        rst_n = 1'b1;
        master_run();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule